// File: doc/BRIEF.md
# ATA Device Task-File Command Controller

This block is the device end of a parallel ATA register interface. A host reaches it through a strobed register port and sees the usual task-file registers. These are the 16-bit data word, the error byte, the sector count, the sector number, the low and high cylinder bytes, the drive/head byte and the status/command byte. It also sees a device-control register and an alternate status view in the control block. The block decodes a small command set, keeps the busy, ready, data-request, seek-complete and error status flags, and drives the interrupt request line. The interrupt line takes account of the interrupt mask and of which device is selected.

PIO data moves one 16-bit word per data-register access. For a read, each sector is fetched from a synchronous sector store, one word ahead of the host. For a write, each host word goes straight to the store. The store address is the 28-bit logical block address concatenated with the word index inside the 512-byte sector. The store returns read data one cycle after the cycle in which the read strobe is high. The register port and the store port are plain strobes with no back-pressure. The host must leave at least one idle cycle between data-register reads. The block has no DMA path and no cylinder/head/sector addressing.

Top module: `ata_dev_taskfile`

## Requirements
- R1: After reset, the status register reads 0x40 (only ready, bit 6). The error register reads 0x01 and the interrupt line is low. Device 0 (parameter DEV_ID=0) comes up selected.
- R2: A control write (control block, offset 6) with bit 2 set puts the device in soft reset and sets busy (status bit 7). A later control write with bit 2 clear restores the R1 state. Bit 1 of every control write is captured as the interrupt mask (nIEN).
- R3: A command write (offset 7) to a selected idle device sets busy and clears data-request (bit 3) in the next cycle. It also clears the error bit (bit 0) and the error register.
- R4: A non-data command (0x10, 0x40, 0x70, 0xC6, 0xE0, 0xE7, 0xEF) completes one cycle later with busy clear. If nIEN is clear, the interrupt line is raised; a primary status read (offset 7) then clears it.
- R5: Command 0xF8 returns capacity minus one. Bits 7:0 go to the sector number, bits 15:8 to cylinder low and bits 23:16 to cylinder high. Bits 27:24 replace drive/head bits 3:0.
- R6: An unknown opcode, or a read (0x20/0x21) or write (0x30/0x31) with drive/head bit 6 (LBA) clear, completes with status bit 0 set and error register 0x04. Its interrupt follows R4.
- R7: On a PIO read, each sector becomes ready with status 0x48 and the data register preloaded with word 0. With nIEN clear, the interrupt is raised, and data reads are ignored until a primary status read clears it.
- R8: Each data read advances one word. After word 255 of the last sector, status returns to 0x40 with no interrupt. After word 255 of any other sector, status shows busy without data-request until the next sector is ready. A sector count of 0 means 256 sectors.
- R9: On a PIO write, the first sector is offered with data-request and no interrupt. After each 256th word, busy and seek-complete (bit 4) are set and data-request is cleared. Later sectors raise the interrupt (nIEN clear) and wait for a status read. After the last sector, status is 0x50 and the interrupt follows R4.
- R10: An alternate status read (control block, offset 6) returns status and leaves the interrupt untouched.
- R11: A drive/head write whose bit 4 differs from DEV_ID, made while idle, deselects the device. The interrupt drops and command writes are ignored. Reselecting with an interrupt still pending and nIEN clear raises it again.
- R12: With nIEN set, the interrupt line stays low.
- R13: The sector store address is {LBA[27:0], word[7:0]}, where the LBA is {drive/head[3:0], cylinder high, cylinder low, sector number}. It increments by one per sector, and a read strobe never coincides with a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_cs_ctl | input | 1 | 1 selects the control block, 0 the command block |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register (combinational) |
| intrq | output | 1 | Interrupt request |
| st_addr | output | 36 | Sector store word address |
| st_rd | output | 1 | Sector store read strobe |
| st_wr | output | 1 | Sector store write strobe |
| st_wdata | output | 16 | Sector store write data |
| st_rdata | input | 16 | Sector store read data, valid one cycle after st_rd |

## Verification
The host read of the last word of a sector has to do two things in the same cycle: retire that word and roll the sector counter on to the next LBA. It must do this without issuing a stale store read. The bench provokes this by reading exactly 256 words and then peeking the alternate status at once, where it expects busy without data-request. The first word returned afterwards must carry the next sector's address. A status read that clears the interrupt is also combined with transfer gating: data reads made before it must leave the word index where it was.

// File: rtl/ata_dev_pkg.sv
`timescale 1ns/1ps
package ata_dev_pkg;

  localparam int LBA_W = 28;
  localparam int WPS   = 256;
  localparam int WW    = $clog2(WPS);

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_ERR   = 3'd1;
  localparam logic [2:0] OFS_CNT   = 3'd2;
  localparam logic [2:0] OFS_SNUM  = 3'd3;
  localparam logic [2:0] OFS_CLO   = 3'd4;
  localparam logic [2:0] OFS_CHI   = 3'd5;
  localparam logic [2:0] OFS_DRV   = 3'd6;
  localparam logic [2:0] OFS_CMD   = 3'd7;
  localparam logic [2:0] OFS_DCTL  = 3'd6;

  localparam int CTL_SRST = 2;
  localparam int CTL_NIEN = 1;
  localparam int DRV_LBA  = 6;
  localparam int DRV_DEV  = 4;

  localparam logic [7:0] ERR_ABORT = 8'h04;
  localparam logic [7:0] ERR_DIAG  = 8'h01;

  typedef enum logic [3:0] {
    ST_SRST, ST_IDLE_S, ST_IDLE_SI, ST_IDLE_NS, ST_EXEC,
    ST_FETCH, ST_PRELOAD, ST_IN_WAIT, ST_IN_XFER,
    ST_OUT_NEXT, ST_OUT_WAIT, ST_OUT_XFER
  } dev_state_e;

  typedef enum logic [2:0] {
    CK_BAD, CK_NODATA, CK_NATMAX, CK_PIO_IN, CK_PIO_OUT
  } cmd_class_e;

endpackage

// File: rtl/ata_cmd_class.sv
`timescale 1ns/1ps
module ata_cmd_class
  import ata_dev_pkg::*;
(
  input  logic [7:0] opcode,
  output cmd_class_e cls,
  output logic       needs_lba
);
  always_comb begin
    needs_lba = 1'b0;
    case (opcode)
      8'h20, 8'h21: begin cls = CK_PIO_IN;  needs_lba = 1'b1; end
      8'h30, 8'h31: begin cls = CK_PIO_OUT; needs_lba = 1'b1; end
      8'hF8:        cls = CK_NATMAX;
      8'h10, 8'h40, 8'h70, 8'hC6, 8'hE0, 8'hE7, 8'hEF: cls = CK_NODATA;
      default:      cls = CK_BAD;
    endcase
  end
endmodule

// File: rtl/ata_xfer_ctr.sv
`timescale 1ns/1ps
module ata_xfer_ctr
  import ata_dev_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LBA_W-1:0] lba_in,
  input  logic [7:0]       cnt_in,
  input  logic             word_inc,
  input  logic             sec_adv,
  output logic [WW-1:0]    word_q,
  output logic [LBA_W-1:0] lba_q,
  output logic             last_word,
  output logic             last_sector,
  output logic             none_left
);
  localparam int CW = 9;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      lba_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      word_q <= '0;
      lba_q  <= lba_in;
      left_q <= (cnt_in == 8'd0) ? CW'(256) : CW'(cnt_in);
    end else if (sec_adv) begin
      word_q <= '0;
      lba_q  <= lba_q + LBA_W'(1);
      left_q <= left_q - CW'(1);
    end else if (word_inc) begin
      word_q <= word_q + WW'(1);
    end
  end

  assign last_word   = (word_q == WW'(WPS - 1));
  assign last_sector = (left_q == CW'(1));
  assign none_left   = (left_q == '0);
endmodule

// File: rtl/ata_dev_taskfile.sv
`timescale 1ns/1ps
module ata_dev_taskfile
  import ata_dev_pkg::*;
#(
  parameter logic        DEV_ID   = 1'b0,
  parameter logic [31:0] CAPACITY = 32'h0234_5679
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_cs_ctl,
  input  logic [2:0]          reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [15:0]         reg_wdata,
  output logic [15:0]         reg_rdata,
  output logic                intrq,
  output logic [LBA_W+WW-1:0] st_addr,
  output logic                st_rd,
  output logic                st_wr,
  output logic [15:0]         st_wdata,
  input  logic [15:0]         st_rdata
);
  localparam logic [27:0] MAX_LBA = 28'(CAPACITY - 32'd1);

  dev_state_e state_q;
  logic bsy_q, dsc_q, drq_q, err_q, pend_q, nien_q, ld_q;
  logic [7:0]  errreg_q, cnt_q, snum_q, clo_q, chi_q, drv_q, cmd_q;
  logic [15:0] data_q;
  logic [7:0]  status_w;

  // host strobes
  logic cmd_wr, cmd_rd, ctl_wr;
  logic wr_data, wr_cmd, wr_drv, rd_stat, rd_data;
  logic srst_set, srst_rel, start_cmd, sel_hit;
  assign cmd_wr   = reg_wr & ~reg_cs_ctl;
  assign cmd_rd   = reg_rd & ~reg_cs_ctl;
  assign ctl_wr   = reg_wr & reg_cs_ctl & (reg_addr == OFS_DCTL);
  assign wr_data  = cmd_wr & (reg_addr == OFS_DATA);
  assign wr_cmd   = cmd_wr & (reg_addr == OFS_CMD);
  assign wr_drv   = cmd_wr & (reg_addr == OFS_DRV);
  assign rd_stat  = cmd_rd & (reg_addr == OFS_CMD);
  assign rd_data  = cmd_rd & (reg_addr == OFS_DATA);
  assign srst_set = ctl_wr & reg_wdata[CTL_SRST];
  assign srst_rel = ctl_wr & ~reg_wdata[CTL_SRST] & (state_q == ST_SRST);
  assign sel_hit  = (reg_wdata[DRV_DEV] == DEV_ID);
  assign start_cmd = wr_cmd & ((state_q == ST_IDLE_S) | (state_q == ST_IDLE_SI));

  // command classification
  cmd_class_e cls;
  logic needs_lba;
  ata_cmd_class u_cls (.opcode(cmd_q), .cls(cls), .needs_lba(needs_lba));

  // sector / word sequencing
  logic [WW-1:0]    word_q;
  logic [LBA_W-1:0] lba_q;
  logic last_word, last_sector, none_left, word_inc, sec_adv, in_step, out_step;
  assign in_step  = (state_q == ST_IN_XFER)  & rd_data;
  assign out_step = (state_q == ST_OUT_XFER) & wr_data;
  assign word_inc = (in_step | out_step) & ~last_word;
  assign sec_adv  = (in_step | out_step) & last_word;

  ata_xfer_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start_cmd),
    .lba_in({drv_q[3:0], chi_q, clo_q, snum_q}), .cnt_in(cnt_q),
    .word_inc(word_inc), .sec_adv(sec_adv),
    .word_q(word_q), .lba_q(lba_q), .last_word(last_word),
    .last_sector(last_sector), .none_left(none_left)
  );

  // sector store port: reads run one word ahead of the host
  assign st_rd    = (state_q == ST_FETCH) | (in_step & ~last_word);
  assign st_wr    = out_step;
  assign st_wdata = reg_wdata;
  assign st_addr  = {lba_q, (state_q == ST_IN_XFER) ? word_q + WW'(1) : word_q};

  assign status_w = {bsy_q, 1'b1, 1'b0, dsc_q, drq_q, 2'b00, err_q};
  assign intrq    = pend_q & ~nien_q & (state_q != ST_IDLE_NS);

  always_comb begin
    reg_rdata = 16'h0000;
    if (reg_cs_ctl) begin
      if (reg_addr == OFS_DCTL) reg_rdata = {8'h00, status_w};
    end else begin
      case (reg_addr)
        OFS_DATA: reg_rdata = data_q;
        OFS_ERR:  reg_rdata = {8'h00, errreg_q};
        OFS_CNT:  reg_rdata = {8'h00, cnt_q};
        OFS_SNUM: reg_rdata = {8'h00, snum_q};
        OFS_CLO:  reg_rdata = {8'h00, clo_q};
        OFS_CHI:  reg_rdata = {8'h00, chi_q};
        OFS_DRV:  reg_rdata = {8'h00, drv_q};
        default:  reg_rdata = {8'h00, status_w};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) nien_q <= 1'b0;
    else if (ctl_wr) nien_q <= reg_wdata[CTL_NIEN];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ld_q <= 1'b0;
    else        ld_q <= st_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst_rel) begin
      state_q  <= DEV_ID ? ST_IDLE_NS : ST_IDLE_S;
      bsy_q <= 1'b0; dsc_q <= 1'b0; drq_q <= 1'b0; err_q <= 1'b0; pend_q <= 1'b0;
      errreg_q <= ERR_DIAG;
      cnt_q <= '0; snum_q <= '0; clo_q <= '0; chi_q <= '0; drv_q <= '0; cmd_q <= '0;
      data_q <= '0;
    end else if (srst_set) begin
      state_q <= ST_SRST;
      bsy_q   <= 1'b1;
      drq_q   <= 1'b0;
    end else if (state_q != ST_SRST) begin
      if (ld_q)    data_q <= st_rdata;
      if (wr_data) data_q <= reg_wdata;
      if (cmd_wr) begin
        case (reg_addr)
          OFS_CNT:  cnt_q  <= reg_wdata[7:0];
          OFS_SNUM: snum_q <= reg_wdata[7:0];
          OFS_CLO:  clo_q  <= reg_wdata[7:0];
          OFS_CHI:  chi_q  <= reg_wdata[7:0];
          OFS_DRV:  drv_q  <= reg_wdata[7:0];
          default: ;
        endcase
      end
      if (start_cmd) begin
        cmd_q <= reg_wdata[7:0];
        bsy_q <= 1'b1; drq_q <= 1'b0; err_q <= 1'b0; errreg_q <= 8'h00;
        pend_q <= 1'b0;
        state_q <= ST_EXEC;
      end else begin
        case (state_q)
          ST_IDLE_S:  if (wr_drv && !sel_hit) state_q <= ST_IDLE_NS;
          ST_IDLE_SI: begin
            if (wr_drv && !sel_hit) state_q <= ST_IDLE_NS;
            else if (rd_stat) begin state_q <= ST_IDLE_S; pend_q <= 1'b0; end
          end
          ST_IDLE_NS: if (wr_drv && sel_hit) begin
            if (pend_q && !nien_q) state_q <= ST_IDLE_SI;
            else begin state_q <= ST_IDLE_S; pend_q <= 1'b0; end
          end
          ST_EXEC: begin
            if (cls == CK_BAD || (needs_lba && !drv_q[DRV_LBA])) begin
              err_q <= 1'b1; errreg_q <= ERR_ABORT;
              bsy_q <= 1'b0; pend_q <= ~nien_q;
              state_q <= nien_q ? ST_IDLE_S : ST_IDLE_SI;
            end else if (cls == CK_PIO_IN) begin
              state_q <= ST_FETCH;
            end else if (cls == CK_PIO_OUT) begin
              bsy_q <= 1'b0; drq_q <= 1'b1; state_q <= ST_OUT_XFER;
            end else begin
              if (cls == CK_NATMAX) begin
                snum_q <= MAX_LBA[7:0];
                clo_q  <= MAX_LBA[15:8];
                chi_q  <= MAX_LBA[23:16];
                drv_q  <= {drv_q[7:4], MAX_LBA[27:24]};
              end
              bsy_q <= 1'b0; pend_q <= ~nien_q;
              state_q <= nien_q ? ST_IDLE_S : ST_IDLE_SI;
            end
          end
          ST_FETCH:   state_q <= ST_PRELOAD;
          ST_PRELOAD: begin
            bsy_q <= 1'b0; drq_q <= 1'b1; pend_q <= ~nien_q;
            state_q <= nien_q ? ST_IN_XFER : ST_IN_WAIT;
          end
          ST_IN_WAIT: if (rd_stat) begin pend_q <= 1'b0; state_q <= ST_IN_XFER; end
          ST_IN_XFER: if (rd_data && last_word) begin
            drq_q <= 1'b0;
            if (last_sector) begin bsy_q <= 1'b0; state_q <= ST_IDLE_S; end
            else begin bsy_q <= 1'b1; state_q <= ST_FETCH; end
          end
          ST_OUT_XFER: if (wr_data && last_word) begin
            bsy_q <= 1'b1; dsc_q <= 1'b1; drq_q <= 1'b0; state_q <= ST_OUT_NEXT;
          end
          ST_OUT_NEXT: begin
            bsy_q <= 1'b0; pend_q <= ~nien_q;
            if (none_left) state_q <= nien_q ? ST_IDLE_S : ST_IDLE_SI;
            else begin
              drq_q <= 1'b1;
              state_q <= nien_q ? ST_OUT_XFER : ST_OUT_WAIT;
            end
          end
          ST_OUT_WAIT: if (rd_stat) begin pend_q <= 1'b0; state_q <= ST_OUT_XFER; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ata_dev_taskfile_chk.sv
`timescale 1ns/1ps
module ata_dev_taskfile_chk
  import ata_dev_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       reg_cs_ctl,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       start_cmd,
  input logic       srst_set,
  input logic       intrq,
  input logic       st_rd,
  input logic       st_wr,
  input logic       bsy,
  input logic       drq,
  input dev_state_e state
);
  assert_cmd_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> (bsy && !drq));

  assert_srst_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    srst_set |=> bsy);

  assert_busy_drq_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsy && drq));

  assert_alt_keeps_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE_SI && intrq && reg_rd && reg_cs_ctl && !reg_wr) |=> intrq);

  assert_deselect_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE_NS) |-> !intrq);

  assert_store_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_rd && st_wr));
endmodule

bind ata_dev_taskfile ata_dev_taskfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_cs_ctl(reg_cs_ctl), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .start_cmd(start_cmd), .srst_set(srst_set),
  .intrq(intrq), .st_rd(st_rd), .st_wr(st_wr),
  .bsy(bsy_q), .drq(drq_q), .state(state_q)
);

// File: tb/ata_dev_taskfile_tb.sv
`timescale 1ns/1ps
module ata_dev_taskfile_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_cs_ctl = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic intrq;
  logic [35:0] st_addr;
  logic st_rd, st_wr;
  logic [15:0] st_wdata;
  logic [15:0] st_rdata = 16'h0;

  int n_tests = 0, n_fail = 0;
  logic [15:0] v;
  logic cap_we;
  logic [35:0] cap_addr;
  logic [15:0] cap_dat;

  always #5 clk = ~clk;

  ata_dev_taskfile u_dut (
    .clk(clk), .rst_n(rst_n), .reg_cs_ctl(reg_cs_ctl), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .intrq(intrq), .st_addr(st_addr), .st_rd(st_rd), .st_wr(st_wr),
    .st_wdata(st_wdata), .st_rdata(st_rdata)
  );

  // sector store model: word content is a function of its address
  function automatic logic [15:0] fmem(input logic [35:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction
  always_ff @(posedge clk) if (st_rd) st_rdata <= fmem(st_addr);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ctl, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_cs_ctl = ctl; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    #1;
    cap_we = st_wr; cap_addr = st_addr; cap_dat = st_wdata;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic ctl, input logic [2:0] a);
    @(negedge clk);
    reg_cs_ctl = ctl; reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek();
    reg_cs_ctl = 1'b1; reg_addr = 3'd6;
    #1 v = reg_rdata;
  endtask

  // {opcode, drive, nIEN, status, error, irq}
  localparam logic [39:0] VEC [0:5] = '{
    40'h10_E0_00_40_0_1,
    40'hEF_E0_01_40_0_0,
    40'h99_E0_00_41_4_1,
    40'h20_A0_00_41_4_1,
    40'h30_A0_01_41_4_0,
    40'hE7_E0_00_40_0_1
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(); chk("R1 status", v, 16'h0040);
    rd(1'b0, 3'd1); chk("R1 error", v, 16'h0001);
    chk("R1 intrq", {15'd0, intrq}, 16'd0);

    // table of non-data and aborted commands
    for (int i = 0; i < 6; i++) begin
      wr(1'b1, 3'd6, {14'd0, VEC[i][23:16] == 8'h01, 1'b0});
      wr(1'b0, 3'd6, {8'h00, VEC[i][31:24]});
      wr(1'b0, 3'd7, {8'h00, VEC[i][39:32]});
      peek(); chk("R3 busy after command", v, 16'h00C0);
      @(negedge clk);
      peek(); chk("R4/R6 status", v, {8'h00, VEC[i][15:8]});
      rd(1'b0, 3'd1); chk("R6 error reg", v, {12'd0, VEC[i][7:4]});
      chk("R4/R12 intrq", {15'd0, intrq}, {12'd0, VEC[i][3:0]});
      rd(1'b0, 3'd7);
      chk("R4 intrq after status read", {15'd0, intrq}, 16'd0);
    end

    // R5 native max
    wr(1'b1, 3'd6, 16'h0002);
    wr(1'b0, 3'd6, 16'h00E0);
    wr(1'b0, 3'd7, 16'h00F8);
    repeat (2) @(negedge clk);
    rd(1'b0, 3'd3); chk("R5 sector number", v, 16'h0078);
    rd(1'b0, 3'd4); chk("R5 cyl low", v, 16'h0056);
    rd(1'b0, 3'd5); chk("R5 cyl high", v, 16'h0034);
    rd(1'b0, 3'd6); chk("R5 head nibble", v, 16'h00E2);

    // R7 / R8 / R13 PIO read, 2 sectors from LBA 5, interrupts enabled
    wr(1'b1, 3'd6, 16'h0000);
    wr(1'b0, 3'd2, 16'h0002);
    wr(1'b0, 3'd3, 16'h0005);
    wr(1'b0, 3'd4, 16'h0000);
    wr(1'b0, 3'd5, 16'h0000);
    wr(1'b0, 3'd6, 16'h00E0);
    wr(1'b0, 3'd7, 16'h0020);
    repeat (4) @(negedge clk);
    peek(); chk("R7 data ready status", v, 16'h0048);
    chk("R7 intrq raised", {15'd0, intrq}, 16'd1);
    rd(1'b0, 3'd0); chk("R7 preload word 0", v, fmem(36'h000_0005_00));
    rd(1'b0, 3'd0); chk("R7 read ignored before status", v, fmem(36'h000_0005_00));
    rd(1'b0, 3'd7);
    chk("R7 intrq cleared", {15'd0, intrq}, 16'd0);
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 256; w++) begin
        rd(1'b0, 3'd0);
        chk("R8/R13 read word", v, fmem({20'd0, 8'(5 + s), 8'(w)}));
      end
      peek();
      if (s == 0) begin
        chk("R8 busy between sectors", v, 16'h00C0);
        repeat (3) @(negedge clk);
        chk("R7 intrq next sector", {15'd0, intrq}, 16'd1);
        rd(1'b0, 3'd7);
      end else begin
        chk("R8 read done status", v, 16'h0040);
        chk("R8 no intrq at end", {15'd0, intrq}, 16'd0);
      end
    end

    // R10 / R11 / R12 interrupt handling
    wr(1'b0, 3'd7, 16'h0010);
    @(negedge clk);
    chk("R4 intrq set", {15'd0, intrq}, 16'd1);
    rd(1'b1, 3'd6); chk("R10 alt status value", v, 16'h0040);
    chk("R10 intrq kept", {15'd0, intrq}, 16'd1);
    wr(1'b0, 3'd6, 16'h00F0);
    chk("R11 deselect drops intrq", {15'd0, intrq}, 16'd0);
    wr(1'b0, 3'd7, 16'h0010);
    peek(); chk("R11 command ignored", v, 16'h0040);
    wr(1'b0, 3'd6, 16'h00E0);
    chk("R11 reselect raises intrq", {15'd0, intrq}, 16'd1);
    wr(1'b1, 3'd6, 16'h0002);
    chk("R12 nIEN masks intrq", {15'd0, intrq}, 16'd0);
    wr(1'b1, 3'd6, 16'h0000);
    chk("R12 unmask", {15'd0, intrq}, 16'd1);
    rd(1'b0, 3'd7);
    chk("R4 cleared", {15'd0, intrq}, 16'd0);

    // R9 / R13 PIO write, 2 sectors from LBA 0x10
    wr(1'b0, 3'd2, 16'h0002);
    wr(1'b0, 3'd3, 16'h0010);
    wr(1'b0, 3'd7, 16'h0030);
    @(negedge clk);
    peek(); chk("R9 first block status", v, 16'h0048);
    chk("R9 no intrq first block", {15'd0, intrq}, 16'd0);
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 256; w++) begin
        wr(1'b0, 3'd0, 16'(w) ^ 16'h1234 ^ 16'(s));
        chk("R9/R13 store write", {cap_we, cap_addr[14:0]}, {1'b1, 7'(16 + s), 8'(w)});
        chk("R9 store data", cap_dat, 16'(w) ^ 16'h1234 ^ 16'(s));
      end
      peek(); chk("R9 busy+seek after block", v, 16'h00D0);
      @(negedge clk);
      peek();
      chk("R9 status after block", v, (s == 0) ? 16'h0058 : 16'h0050);
      chk("R9 intrq after block", {15'd0, intrq}, 16'd1);
      rd(1'b0, 3'd7);
    end

    // R8 sector count 0 runs past one sector
    wr(1'b1, 3'd6, 16'h0002);
    wr(1'b0, 3'd2, 16'h0000);
    wr(1'b0, 3'd7, 16'h0020);
    repeat (4) @(negedge clk);
    for (int w = 0; w < 256; w++) rd(1'b0, 3'd0);
    peek(); chk("R8 count 0 continues", v, 16'h00D0);
    repeat (3) @(negedge clk);
    peek(); chk("R8 count 0 second sector", v, 16'h0058);

    // R2 soft reset
    wr(1'b1, 3'd6, 16'h0004);
    peek(); chk("R2 srst busy", v & 16'h0080, 16'h0080);
    wr(1'b1, 3'd6, 16'h0000);
    peek(); chk("R2 status after release", v, 16'h0040);
    rd(1'b0, 3'd1); chk("R2 error after release", v, 16'h0001);
    chk("R2 intrq after release", {15'd0, intrq}, 16'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule